// File: doc/BRIEF.md
# Misaligned Access Fault Classifier

This block sits beside the address path of a load/store unit. For every data access it decides whether the access is misaligned and whether it spills across a 4 KiB page or across two physical-memory regions. It also decides whether the access may complete, complete without atomicity, or trap. When it traps, the block chooses the cause code and the trap value. Translation has already been done upstream. The block receives permission results for the pages that hold the first and last bytes, a region identifier and an atomic-capability flag for both physical bytes, and a hint that tells it whether the physical pair formed from the first byte would itself fault.

The verdict is registered, so it appears one cycle after the request. Three build-time knobs select the implementation options:

- `SINGLE_MODE`: within one region, 0 keeps loads and stores atomic; 1 makes them non-atomic and faults every atomic operation.
- `SPLIT_POLICY`: for a load or store that spans two regions, 0 faults, 1 completes non-atomically, and 2 completes partially, then faults with writeback suppressed.
- `ALT_ACCESS`: when set, an access fault may replace the page fault on the last page.

Top module: `ma_fault_classifier`

## Requirements
- R1: With size code s (0,1,2,3 meaning 1,2,4,8 bytes), the access is misaligned exactly when the address is not a multiple of 2^s. An aligned access reports misaligned=0, split=0, exc=0, nonatomic=0 and no_wb=0.
- R2: Every output is registered. rsp_valid is high exactly one cycle after req_valid. All outputs are zero while rsp_valid is low and after reset.
- R3: For a misaligned access whose first page is not permitted, the block raises a page fault with tval equal to the request address. This check takes priority over every other check.
- R4: If the first page is permitted, the last byte (address + 2^s − 1) lies in a different 4 KiB page, and that page is not permitted, the block raises a page fault with tval equal to the last-byte address with its low 12 bits cleared. perm_last has no effect when no page is crossed.
- R5: With ALT_ACCESS=1, in the R4 case with pa_pair_fault high, the block raises an access fault with tval equal to the request address instead.
- R6: split is high when a misaligned access crosses a page or has region_first different from region_last.
- R7: Op codes 2 (AMO), 3 (LR) and 4 (SC) count as atomic operations. A permitted misaligned atomic operation whose region identifiers differ raises an access fault with tval equal to the request address.
- R8: With SINGLE_MODE=0, a same-region misaligned load or store completes atomically (exc=0, nonatomic=0). A same-region atomic operation completes when atom_first and atom_last are both set, and raises an access fault otherwise.
- R9: With SINGLE_MODE=1, a same-region misaligned load or store completes with nonatomic=1, and a same-region atomic operation raises an access fault.
- R10: A permitted misaligned load or store whose region identifiers differ follows SPLIT_POLICY. Policy 0 raises an access fault. Policy 1 completes with nonatomic=1. Policy 2 raises an access fault with no_wb=1. no_wb is never set in any other case.
- R11: Op code 0 (load), op code 3 (LR) and codes 5 to 7 use cause 13 for a page fault and 5 for an access fault. Op code 1 (store), op code 2 (AMO) and op code 4 (SC) use causes 15 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_vaddr | input | ADDR_W | Virtual address of the first byte |
| req_size | input | 2 | Size code, bytes = 2^code |
| req_op | input | 3 | Operation: 0 load, 1 store, 2 AMO, 3 LR, 4 SC |
| perm_first | input | 1 | Page of first byte is permitted |
| perm_last | input | 1 | Page of last byte is permitted |
| region_first | input | REGION_W | Physical region of first byte |
| region_last | input | REGION_W | Physical region of last byte |
| atom_first | input | 1 | First region supports atomic access |
| atom_last | input | 1 | Last region supports atomic access |
| pa_pair_fault | input | 1 | Physical pair from first byte would fault |
| rsp_valid | output | 1 | Verdict valid |
| rsp_misaligned | output | 1 | Access is misaligned |
| rsp_split | output | 1 | Access crosses a page or region |
| rsp_exc | output | 1 | Exception raised |
| rsp_cause | output | 5 | Exception cause code |
| rsp_tval | output | ADDR_W | Trap value |
| rsp_nonatomic | output | 1 | Completes without atomicity |
| rsp_no_wb | output | 1 | Partial access, register writeback suppressed |

## Verification
The assertions check the following on every cycle:

- a trap never comes without misalignment;
- an aligned verdict stays quiet;
- a first-page fault always reports the request address and a page cause;
- an atomic operation across regions always faults;
- no_wb implies an exception;
- the cause code is always one of the four legal values.

Only the bench's sweep can show the choice of trap value on a crossing into a forbidden page, the effect of each policy setting, and that perm_last is ignored inside one page. The sweep runs three differently configured instances against an arithmetic model.

// File: rtl/ma_pkg.sv
package ma_pkg;

  typedef enum logic [2:0] {
    OP_LOAD  = 3'd0,
    OP_STORE = 3'd1,
    OP_AMO   = 3'd2,
    OP_LR    = 3'd3,
    OP_SC    = 3'd4
  } op_e;

  localparam logic [4:0] CAUSE_LD_ACCESS = 5'd5;
  localparam logic [4:0] CAUSE_ST_ACCESS = 5'd7;
  localparam logic [4:0] CAUSE_LD_PAGE   = 5'd13;
  localparam logic [4:0] CAUSE_ST_PAGE   = 5'd15;

  // byte-offset mask for a size code: 2^code - 1
  function automatic logic [3:0] size_mask(input logic [1:0] code);
    return 4'((5'd1 << code) - 5'd1);
  endfunction

  function automatic logic is_atomic_op(input logic [2:0] op);
    return (op == OP_AMO) || (op == OP_LR) || (op == OP_SC);
  endfunction

  // store-class ops write memory and use the store cause codes
  function automatic logic is_store_class(input logic [2:0] op);
    return (op == OP_STORE) || (op == OP_AMO) || (op == OP_SC);
  endfunction

  function automatic logic [4:0] cause_of(input logic [2:0] op, input logic page);
    if (is_store_class(op)) return page ? CAUSE_ST_PAGE : CAUSE_ST_ACCESS;
    return page ? CAUSE_LD_PAGE : CAUSE_LD_ACCESS;
  endfunction

endpackage

// File: rtl/ma_geom.sv
module ma_geom #(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12
) (
  input  logic [ADDR_W-1:0] vaddr,
  input  logic [1:0]        size_code,
  output logic              misaligned,
  output logic              page_cross,
  output logic [ADDR_W-1:0] last_addr,
  output logic [ADDR_W-1:0] last_page_base
);
  import ma_pkg::*;

  localparam int VPN_W = ADDR_W - PAGE_BITS;

  logic [3:0]       low_mask;
  logic [VPN_W-1:0] vpn_first;
  logic [VPN_W-1:0] vpn_last;

  always_comb begin
    low_mask       = size_mask(size_code);
    misaligned     = |(vaddr[2:0] & low_mask[2:0]);
    last_addr      = vaddr + ADDR_W'(low_mask);
    vpn_first      = vaddr[ADDR_W-1:PAGE_BITS];
    vpn_last       = last_addr[ADDR_W-1:PAGE_BITS];
    page_cross     = (vpn_first != vpn_last);
    last_page_base = {vpn_last, {PAGE_BITS{1'b0}}};
  end

endmodule

// File: rtl/ma_virt_check.sv
module ma_virt_check #(
  parameter bit ALT_ACCESS = 1'b0
) (
  input  logic misaligned,
  input  logic page_cross,
  input  logic perm_first,
  input  logic perm_last,
  input  logic pa_pair_fault,
  output logic pf_first,
  output logic pf_last,
  output logic acc_alt,
  output logic virt_ok
);
  logic last_bad;

  always_comb begin
    pf_first = misaligned && !perm_first;
    last_bad = misaligned && perm_first && page_cross && !perm_last;
    acc_alt  = last_bad && ALT_ACCESS && pa_pair_fault;
    pf_last  = last_bad && !acc_alt;
    virt_ok  = misaligned && !pf_first && !last_bad;
  end

endmodule

// File: rtl/ma_phys_policy.sv
module ma_phys_policy #(
  parameter int SINGLE_MODE  = 0,
  parameter int SPLIT_POLICY = 0
) (
  input  logic       virt_ok,
  input  logic [2:0] op,
  input  logic       region_cross,
  input  logic       atom_ok,
  output logic       acc_fault,
  output logic       nonatomic,
  output logic       no_wb
);
  import ma_pkg::*;

  logic atomic;
  logic ls_split_fault;
  logic ls_split_nonatomic;
  logic ls_split_nowb;
  logic single_atomic_fault;
  logic single_ls_nonatomic;

  assign atomic = is_atomic_op(op);

  generate
    if (SPLIT_POLICY == 1) begin : g_split_nonatomic
      assign ls_split_fault     = 1'b0;
      assign ls_split_nonatomic = 1'b1;
      assign ls_split_nowb      = 1'b0;
    end else if (SPLIT_POLICY == 2) begin : g_split_partial
      assign ls_split_fault     = 1'b1;
      assign ls_split_nonatomic = 1'b0;
      assign ls_split_nowb      = 1'b1;
    end else begin : g_split_fault
      assign ls_split_fault     = 1'b1;
      assign ls_split_nonatomic = 1'b0;
      assign ls_split_nowb      = 1'b0;
    end

    if (SINGLE_MODE == 1) begin : g_single_weak
      assign single_atomic_fault = 1'b1;
      assign single_ls_nonatomic = 1'b1;
    end else begin : g_single_strong
      assign single_atomic_fault = !atom_ok;
      assign single_ls_nonatomic = 1'b0;
    end
  endgenerate

  always_comb begin
    acc_fault = 1'b0;
    nonatomic = 1'b0;
    no_wb     = 1'b0;
    if (virt_ok) begin
      if (atomic) begin
        acc_fault = region_cross || single_atomic_fault;
      end else if (region_cross) begin
        acc_fault = ls_split_fault;
        nonatomic = ls_split_nonatomic;
        no_wb     = ls_split_nowb;
      end else begin
        nonatomic = single_ls_nonatomic;
      end
    end
  end

endmodule

// File: rtl/ma_fault_classifier.sv
module ma_fault_classifier #(
  parameter int ADDR_W       = 32,
  parameter int PAGE_BITS    = 12,
  parameter int REGION_W     = 4,
  parameter int SINGLE_MODE  = 0,
  parameter int SPLIT_POLICY = 0,
  parameter bit ALT_ACCESS   = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [ADDR_W-1:0]   req_vaddr,
  input  logic [1:0]          req_size,
  input  logic [2:0]          req_op,
  input  logic                perm_first,
  input  logic                perm_last,
  input  logic [REGION_W-1:0] region_first,
  input  logic [REGION_W-1:0] region_last,
  input  logic                atom_first,
  input  logic                atom_last,
  input  logic                pa_pair_fault,
  output logic                rsp_valid,
  output logic                rsp_misaligned,
  output logic                rsp_split,
  output logic                rsp_exc,
  output logic [4:0]          rsp_cause,
  output logic [ADDR_W-1:0]   rsp_tval,
  output logic                rsp_nonatomic,
  output logic                rsp_no_wb
);
  import ma_pkg::*;

  // named internal events
  logic              mis_c;
  logic              page_cross_c;
  logic [ADDR_W-1:0] last_addr_c;
  logic [ADDR_W-1:0] last_base_c;
  logic              pf_first_c;
  logic              pf_last_c;
  logic              acc_alt_c;
  logic              virt_ok_c;
  logic              region_cross_c;
  logic              phys_fault_c;
  logic              phys_nonatomic_c;
  logic              phys_nowb_c;

  logic              exc_n;
  logic [4:0]        cause_n;
  logic [ADDR_W-1:0] tval_n;
  logic              split_n;

  assign region_cross_c = (region_first != region_last);

  ma_geom #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_geom (
    .vaddr          (req_vaddr),
    .size_code      (req_size),
    .misaligned     (mis_c),
    .page_cross     (page_cross_c),
    .last_addr      (last_addr_c),
    .last_page_base (last_base_c)
  );

  ma_virt_check #(.ALT_ACCESS(ALT_ACCESS)) u_virt (
    .misaligned    (mis_c),
    .page_cross    (page_cross_c),
    .perm_first    (perm_first),
    .perm_last     (perm_last),
    .pa_pair_fault (pa_pair_fault),
    .pf_first      (pf_first_c),
    .pf_last       (pf_last_c),
    .acc_alt       (acc_alt_c),
    .virt_ok       (virt_ok_c)
  );

  ma_phys_policy #(.SINGLE_MODE(SINGLE_MODE), .SPLIT_POLICY(SPLIT_POLICY)) u_phys (
    .virt_ok      (virt_ok_c),
    .op           (req_op),
    .region_cross (region_cross_c),
    .atom_ok      (atom_first && atom_last),
    .acc_fault    (phys_fault_c),
    .nonatomic    (phys_nonatomic_c),
    .no_wb        (phys_nowb_c)
  );

  // verdict selection, first-page fault wins
  always_comb begin
    exc_n   = 1'b0;
    cause_n = 5'd0;
    tval_n  = '0;
    split_n = mis_c && (page_cross_c || region_cross_c);
    if (pf_first_c) begin
      exc_n   = 1'b1;
      cause_n = cause_of(req_op, 1'b1);
      tval_n  = req_vaddr;
    end else if (pf_last_c) begin
      exc_n   = 1'b1;
      cause_n = cause_of(req_op, 1'b1);
      tval_n  = last_base_c;
    end else if (acc_alt_c || phys_fault_c) begin
      exc_n   = 1'b1;
      cause_n = cause_of(req_op, 1'b0);
      tval_n  = req_vaddr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid      <= 1'b0;
      rsp_misaligned <= 1'b0;
      rsp_split      <= 1'b0;
      rsp_exc        <= 1'b0;
      rsp_cause      <= 5'd0;
      rsp_tval       <= '0;
      rsp_nonatomic  <= 1'b0;
      rsp_no_wb      <= 1'b0;
    end else begin
      rsp_valid      <= req_valid;
      rsp_misaligned <= req_valid && mis_c;
      rsp_split      <= req_valid && split_n;
      rsp_exc        <= req_valid && exc_n;
      rsp_cause      <= req_valid ? cause_n : 5'd0;
      rsp_tval       <= req_valid ? tval_n : '0;
      rsp_nonatomic  <= req_valid && phys_nonatomic_c;
      rsp_no_wb      <= req_valid && phys_nowb_c;
    end
  end

  // checks next to the verdict register
  assert_exc_needs_misalign_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_exc |-> rsp_misaligned);

  assert_aligned_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_misaligned) |-> (!rsp_exc && !rsp_split && !rsp_nonatomic && !rsp_no_wb));

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!rsp_exc && !rsp_misaligned && !rsp_nonatomic && !rsp_no_wb));

  assert_first_page_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mis_c && !perm_first) |=>
      (rsp_exc && rsp_tval == $past(req_vaddr) &&
       (rsp_cause == CAUSE_LD_PAGE || rsp_cause == CAUSE_ST_PAGE)));

  assert_atomic_split_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && virt_ok_c && is_atomic_op(req_op) && region_cross_c) |=>
      (rsp_exc && (rsp_cause == CAUSE_LD_ACCESS || rsp_cause == CAUSE_ST_ACCESS)));

  assert_exc_not_nonatomic_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_exc && rsp_nonatomic));

  assert_nowb_with_exc_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_no_wb |-> rsp_exc);

  assert_cause_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_exc |-> (rsp_cause == CAUSE_LD_ACCESS || rsp_cause == CAUSE_ST_ACCESS ||
                 rsp_cause == CAUSE_LD_PAGE || rsp_cause == CAUSE_ST_PAGE));

endmodule

// File: tb/sim_ma_fault_classifier.sv
`timescale 1ns/1ps
module sim_ma_fault_classifier;

  localparam int AW = 32;
  localparam int RW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_vaddr = '0;
  logic [1:0]    req_size = '0;
  logic [2:0]    req_op = '0;
  logic          perm_first = 1'b0, perm_last = 1'b0;
  logic [RW-1:0] region_first = '0, region_last = '0;
  logic          atom_first = 1'b0, atom_last = 1'b0;
  logic          pa_pair_fault = 1'b0;

  typedef struct packed {
    logic          v;
    logic          mis;
    logic          split;
    logic          exc;
    logic [4:0]    cause;
    logic [AW-1:0] tval;
    logic          nonat;
    logic          nowb;
  } verdict_t;

  verdict_t got [3];

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  // three configurations: {single mode, split policy, alt access}
  ma_fault_classifier #(.ADDR_W(AW), .REGION_W(RW), .SINGLE_MODE(0), .SPLIT_POLICY(0), .ALT_ACCESS(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr), .req_size(req_size),
    .req_op(req_op), .perm_first(perm_first), .perm_last(perm_last), .region_first(region_first),
    .region_last(region_last), .atom_first(atom_first), .atom_last(atom_last), .pa_pair_fault(pa_pair_fault),
    .rsp_valid(got[0].v), .rsp_misaligned(got[0].mis), .rsp_split(got[0].split), .rsp_exc(got[0].exc),
    .rsp_cause(got[0].cause), .rsp_tval(got[0].tval), .rsp_nonatomic(got[0].nonat), .rsp_no_wb(got[0].nowb));

  ma_fault_classifier #(.ADDR_W(AW), .REGION_W(RW), .SINGLE_MODE(1), .SPLIT_POLICY(1), .ALT_ACCESS(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr), .req_size(req_size),
    .req_op(req_op), .perm_first(perm_first), .perm_last(perm_last), .region_first(region_first),
    .region_last(region_last), .atom_first(atom_first), .atom_last(atom_last), .pa_pair_fault(pa_pair_fault),
    .rsp_valid(got[1].v), .rsp_misaligned(got[1].mis), .rsp_split(got[1].split), .rsp_exc(got[1].exc),
    .rsp_cause(got[1].cause), .rsp_tval(got[1].tval), .rsp_nonatomic(got[1].nonat), .rsp_no_wb(got[1].nowb));

  ma_fault_classifier #(.ADDR_W(AW), .REGION_W(RW), .SINGLE_MODE(0), .SPLIT_POLICY(2), .ALT_ACCESS(1'b0)) u2 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr), .req_size(req_size),
    .req_op(req_op), .perm_first(perm_first), .perm_last(perm_last), .region_first(region_first),
    .region_last(region_last), .atom_first(atom_first), .atom_last(atom_last), .pa_pair_fault(pa_pair_fault),
    .rsp_valid(got[2].v), .rsp_misaligned(got[2].mis), .rsp_split(got[2].split), .rsp_exc(got[2].exc),
    .rsp_cause(got[2].cause), .rsp_tval(got[2].tval), .rsp_nonatomic(got[2].nonat), .rsp_no_wb(got[2].nowb));

  function automatic int cfg_mode(input int k);   return (k == 1) ? 1 : 0; endfunction
  function automatic int cfg_policy(input int k); return k; endfunction
  function automatic bit cfg_alt(input int k);    return (k == 1); endfunction

  // model, written from the requirements
  function automatic verdict_t model(input int k);
    verdict_t e;
    longint unsigned w, last;
    bit pc, rc, ldc, atomic;
    e = '0;
    e.v = 1'b1;
    w = longint'(1) << req_size;
    e.mis = (longint'(req_vaddr) % w) != 0;
    last = (longint'(req_vaddr) + w - 1) & 64'hFFFF_FFFF;
    pc = (longint'(req_vaddr) >> 12) != (last >> 12);
    rc = region_first != region_last;
    ldc = !(req_op == 3'd1 || req_op == 3'd2 || req_op == 3'd4);
    atomic = (req_op == 3'd2 || req_op == 3'd3 || req_op == 3'd4);
    if (!e.mis) return e;
    e.split = pc || rc;
    if (!perm_first) begin
      e.exc = 1; e.cause = ldc ? 5'd13 : 5'd15; e.tval = req_vaddr;
    end else if (pc && !perm_last) begin
      if (cfg_alt(k) && pa_pair_fault) begin
        e.exc = 1; e.cause = ldc ? 5'd5 : 5'd7; e.tval = req_vaddr;
      end else begin
        e.exc = 1; e.cause = ldc ? 5'd13 : 5'd15; e.tval = AW'(last & ~64'hFFF);
      end
    end else if (atomic) begin
      if (rc || cfg_mode(k) == 1 || !(atom_first && atom_last)) begin
        e.exc = 1; e.cause = ldc ? 5'd5 : 5'd7; e.tval = req_vaddr;
      end
    end else if (rc) begin
      if (cfg_policy(k) == 1) e.nonat = 1;
      else begin
        e.exc = 1; e.cause = ldc ? 5'd5 : 5'd7; e.tval = req_vaddr;
        e.nowb = (cfg_policy(k) == 2);
      end
    end else begin
      e.nonat = (cfg_mode(k) == 1);
    end
    return e;
  endfunction

  function automatic string req_tag(input int k);
    longint unsigned w, last;
    bit pc, atomic;
    w = longint'(1) << req_size;
    last = longint'(req_vaddr) + w - 1;
    pc = (longint'(req_vaddr) >> 12) != (last >> 12);
    atomic = (req_op == 3'd2 || req_op == 3'd3 || req_op == 3'd4);
    if ((longint'(req_vaddr) % w) == 0) return "R1";
    if (!perm_first) return "R3";
    if (pc && !perm_last) return (cfg_alt(k) && pa_pair_fault) ? "R5" : "R4";
    if (region_first != region_last) return atomic ? "R7" : "R10";
    return (cfg_mode(k) == 1) ? "R9" : "R8";
  endfunction

  task automatic check_all(input string tag_override);
    verdict_t e;
    string tag;
    for (int k = 0; k < 3; k++) begin
      e = model(k);
      tag = (tag_override != "") ? tag_override : req_tag(k);
      total++;
      if (got[k] !== e) begin
        bad++;
        $display("FAIL %s (split per R6, cause per R11) u%0d addr=%h sz=%0d op=%0d actual=%h expected=%h",
                 tag, k, req_vaddr, req_size, req_op, got[k], e);
      end
    end
  endtask

  task automatic check_idle(input string tag);
    for (int k = 0; k < 3; k++) begin
      total++;
      if (got[k] !== verdict_t'(0)) begin
        bad++;
        $display("FAIL %s u%0d idle actual=%h expected=0", tag, k, got[k]);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] addrs [16];
    for (int i = 0; i < 8; i++) begin
      addrs[i]     = 32'h1234_5000 + AW'(i);
      addrs[i + 8] = 32'h1234_5FF8 + AW'(i);
    end
    repeat (3) @(negedge clk);
    check_idle("R2");            // reset state
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R2");

    for (int a = 0; a < 16; a++)
      for (int s = 0; s < 4; s++)
        for (int o = 0; o < 5; o++)
          for (int m = 0; m < 32; m++) begin
            req_valid     = 1'b1;
            req_vaddr     = addrs[a];
            req_size      = 2'(s);
            req_op        = 3'(o);
            perm_first    = m[0];
            perm_last     = m[1];
            region_first  = 4'd3;
            region_last   = m[2] ? 4'd5 : 4'd3;
            atom_first    = m[3];
            atom_last     = m[3];
            pa_pair_fault = m[4];
            @(negedge clk);
            check_all("");
          end

    // mixed atomic flags: only one region supports atomics (R8)
    req_vaddr = 32'h0000_0102; req_size = 2'd2; req_op = 3'd2;
    perm_first = 1; perm_last = 1; region_first = 4'd1; region_last = 4'd1;
    atom_first = 1; atom_last = 0; pa_pair_fault = 0;
    @(negedge clk);
    check_all("R8");

    // op code 6 behaves as a load (R11)
    req_op = 3'd6; perm_first = 0;
    @(negedge clk);
    check_all("R11");

    // request dropped: outputs return to zero (R2)
    req_valid = 1'b0;
    @(negedge clk);
    check_idle("R2");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule